// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits on the host side of an asynchronous parallel flash with a page-mode read path. A requester hands it word addresses over a valid/ready handshake. For each accepted request the controller presents the address to the flash and asserts chip enable and output enable. It then counts out an access wait in system clock cycles, captures the 16-bit data bus on the last edge of that wait, and returns the word with a single-cycle valid pulse. The flash itself receives no clock.

The flash reads an aligned group of 16 words in one slow initial access. After that, any word of the same group can be read quickly by changing only the four low address bits. The controller keeps the upper address bits of the group it last read as an open-page tag. A request whose upper bits match that tag, while the page is still open, gets the short page wait. Every other request gets the long initial wait.

Chip enable stays asserted between reads so that the open page survives. After a parameterised number of consecutive idle cycles with no accepted request, the controller releases chip enable and forgets the page. The next read then always takes the long wait.

Top module: `pagedFlashReader`

## Requirements
- R1: While reset is held and right after it, reqReady is 1, rspValid is 0, and flashCeN and flashOeN are both 1 (deasserted).
- R2: A request is taken on a clock edge where reqValid and reqReady are both 1. reqReady is 0 from the next cycle until the cycle in which rspValid rises.
- R3: From the cycle after acceptance until the data is captured, flashCeN and flashOeN are 0 and flashAddr holds the requested address unchanged.
- R4: A request that misses the open page produces rspValid exactly INIT_WAIT cycles after the cycle in which it was accepted.
- R5: A request that hits produces rspValid exactly PAGE_WAIT cycles after acceptance. A hit means the page is open and the address bits above the low 4 equal the stored tag.
- R6: rspData equals the flash bus value at the capture edge. rspValid lasts one cycle, and rspData holds its value until the next response.
- R7: A completed access opens the page named by its upper address bits (all bits above bit 3). The low 4 bits select the word within the page and play no part in the hit decision.
- R8: After IDLE_LIMIT consecutive idle cycles with no accepted request (counting from the response cycle), flashCeN goes to 1 and the page is closed. With fewer idle cycles, flashCeN stays 0 and the page stays open.
- R9: flashOeN is 1 in every cycle in which no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Controller can take a request |
| reqAddr | input | ADDR_W | Word address of the request |
| rspValid | output | 1 | One-cycle pulse marking returned data |
| rspData | output | DATA_W | Returned word, held between responses |
| flashAddr | output | ADDR_W | Word address to the flash |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashData | input | DATA_W | Flash data bus |

## Verification
The hardest condition to reach from the ports is the exact edge of the idle timeout. It separates a read that still finds its page open from one that must reopen it. The bench sets idle gaps of exactly IDLE_LIMIT-1 and IDLE_LIMIT cycles after a response, and checks chip enable at the port before issuing the next request.

A flash stub in the bench tracks how long the current address has been stable. It returns an inverted word whenever it is sampled before the short or long wait has elapsed, so a wait that is too short shows up as corrupted data. The bench then sweeps every page of a small address space, and all offsets within several pages, to mix hits and misses.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // latch request address
    logic capture;   // sample flash bus, open page, emit response
    logic dropPage;  // idle timeout: close page
  } pfrStrobe_t;
endpackage

// File: rtl/pfr_ctrl.sv
module pfr_ctrl
  import pfr_pkg::*;
#(
  parameter int INIT_WAIT  = 25,
  parameter int PAGE_WAIT  = 8,
  parameter int IDLE_LIMIT = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pageHit,
  input  logic       pageValid,
  output logic       reqReady,
  output logic       accessOn,
  output pfrStrobe_t strobe
);
  localparam int CNT_W  = $clog2(INIT_WAIT + 1);
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0]  LONG_LOAD  = CNT_W'(INIT_WAIT - 1);
  localparam logic [CNT_W-1:0]  SHORT_LOAD = CNT_W'(PAGE_WAIT - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST  = IDLE_W'(IDLE_LIMIT - 1);

  typedef enum logic {S_IDLE, S_ACCESS} state_t;

  state_t            state;
  logic [CNT_W-1:0]  waitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              idleTick;

  assign reqReady = (state == S_IDLE);
  assign accessOn = (state == S_ACCESS);
  assign idleTick = reqReady && pageValid && !reqValid;

  always_comb begin
    strobe.load     = reqReady && reqValid;
    strobe.capture  = accessOn && (waitCnt == '0);
    strobe.dropPage = idleTick && (idleCnt == IDLE_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          state   <= S_ACCESS;
          waitCnt <= pageHit ? SHORT_LOAD : LONG_LOAD;
        end
        S_ACCESS: if (waitCnt == '0) state <= S_IDLE;
                  else waitCnt <= waitCnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !idleTick || strobe.dropPage) idleCnt <= '0;
    else                                       idleCnt <= idleCnt + 1'b1;
  end
endmodule

// File: rtl/pfr_datapath.sv
module pfr_datapath
  import pfr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfrStrobe_t        strobe,
  input  logic              accessOn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] flashData,
  output logic              pageHit,
  output logic              pageValid,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam int TAG_W = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0] addrReg;
  logic [TAG_W-1:0]  pageTag;

  assign pageHit   = pageValid && (pageTag == reqAddr[ADDR_W-1:PAGE_BITS]);
  assign flashAddr = addrReg;
  assign flashOeN  = !accessOn;
  assign flashCeN  = !(accessOn || pageValid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      pageTag   <= '0;
      pageValid <= 1'b0;
      rspValid  <= 1'b0;
      rspData   <= '0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.load) addrReg <= reqAddr;
      if (strobe.capture) begin
        rspData   <= flashData;
        pageTag   <= addrReg[ADDR_W-1:PAGE_BITS];
        pageValid <= 1'b1;
      end else if (strobe.dropPage) begin
        pageValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pagedFlashReader.sv
module pagedFlashReader
  import pfr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int PAGE_BITS  = 4,
  parameter int INIT_WAIT  = 25,
  parameter int PAGE_WAIT  = 8,
  parameter int IDLE_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashCeN,
  output logic              flashOeN,
  input  logic [DATA_W-1:0] flashData
);
  pfrStrobe_t strobe;
  logic       pageHit;
  logic       pageValid;
  logic       accessOn;

  pfr_ctrl #(
    .INIT_WAIT(INIT_WAIT), .PAGE_WAIT(PAGE_WAIT), .IDLE_LIMIT(IDLE_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pageHit(pageHit),
    .pageValid(pageValid), .reqReady(reqReady), .accessOn(accessOn),
    .strobe(strobe)
  );

  pfr_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accessOn(accessOn),
    .reqAddr(reqAddr), .flashData(flashData), .pageHit(pageHit),
    .pageValid(pageValid), .flashAddr(flashAddr), .flashCeN(flashCeN),
    .flashOeN(flashOeN), .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic [ADDR_W-1:0] flashAddr,
  input logic              flashCeN,
  input logic              flashOeN
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2
  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> !flashCeN); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!flashOeN && $past(!flashOeN)) |-> $stable(flashAddr)); // R3
  AST_RSP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!flashOeN)); // R4
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> $stable(rspData)); // R6
  AST_IDLE_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> flashOeN); // R9
endmodule

bind pagedFlashReader pfr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspData(rspData), .flashAddr(flashAddr),
  .flashCeN(flashCeN), .flashOeN(flashOeN)
);

// File: tb/tb_pagedFlashReader.sv
module tb_pagedFlashReader;
  localparam int ADDR_W = 12, DATA_W = 16, PB = 4;
  localparam int INIT_WAIT = 25, PAGE_WAIT = 8, IDLE_LIMIT = 6;
  localparam int TAG_W = ADDR_W - PB;

  logic clk = 0, rstN = 0, reqValid = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqReady, rspValid, flashCeN, flashOeN;
  logic [DATA_W-1:0] rspData, flashData;
  logic [ADDR_W-1:0] flashAddr;

  always #2 clk = ~clk;

  pagedFlashReader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PB),
    .INIT_WAIT(INIT_WAIT), .PAGE_WAIT(PAGE_WAIT), .IDLE_LIMIT(IDLE_LIMIT)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspData(rspData),
    .flashAddr(flashAddr), .flashCeN(flashCeN), .flashOeN(flashOeN),
    .flashData(flashData));

  function automatic logic [DATA_W-1:0] word(input logic [ADDR_W-1:0] a);
    return 16'({a, 4'b0}) ^ 16'(a * 7) ^ 16'h5A3C;
  endfunction

  // Flash stub: data good only once the address has been stable long enough
  logic [ADDR_W-1:0] stubAddr = '0;
  int                stubAge = 0;
  logic              stubOpen = 0;
  logic [TAG_W-1:0]  stubTag = '0;
  int                stubNeed;
  always_ff @(posedge clk) begin
    if (flashCeN) begin
      stubOpen <= 1'b0; stubAge <= 0; stubAddr <= flashAddr;
    end else if (flashAddr != stubAddr) begin
      stubAddr <= flashAddr; stubAge <= 1;
    end else begin
      if (stubAge < 1000) stubAge <= stubAge + 1;
      if (stubAge + 1 >= INIT_WAIT) begin
        stubOpen <= 1'b1; stubTag <= flashAddr[ADDR_W-1:PB];
      end
    end
  end
  always_comb begin
    stubNeed = (stubOpen && stubTag == flashAddr[ADDR_W-1:PB]) ? PAGE_WAIT : INIT_WAIT;
    flashData = (!flashCeN && !flashOeN && flashAddr == stubAddr && stubAge >= stubNeed - 1)
              ? word(flashAddr) : ~word(flashAddr);
  end

  int checks = 0, errors = 0;
  int idleRun = 0, modelHits = 0, obsHits = 0;
  logic mValid = 0;
  logic [TAG_W-1:0] mTag = '0;
  logic [DATA_W-1:0] lastWord = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idleWait(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idleRun++;
    end
    if (mValid)  // R8: page held below the limit, released at it
      chk(flashCeN == (idleRun >= IDLE_LIMIT), "R8", "ceN after idle",
          32'(flashCeN), 32'(idleRun >= IDLE_LIMIT));
  endtask

  task automatic checkPulse();
    @(negedge clk); idleRun++;
    chk(!rspValid, "R6", "valid pulse width", 32'(rspValid), 0);
    chk(rspData == lastWord, "R6", "data hold", 32'(rspData), 32'(lastWord));
    chk(flashOeN, "R9", "oe idle", 32'(flashOeN), 1);
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input int gap);
    logic expHit;
    int expW, lat;
    bit got;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk); idleRun++;
    end
    if (idleRun >= IDLE_LIMIT) mValid = 0;
    expHit = mValid && (mTag == a[ADDR_W-1:PB]);
    expW = expHit ? PAGE_WAIT : INIT_WAIT;
    reqValid = 1; reqAddr = a;
    @(negedge clk); reqValid = 0;
    chk(!reqReady, "R2", "ready low when busy", 32'(reqReady), 0);
    chk(!flashCeN && !flashOeN && flashAddr == a, "R3", "flash strobes/addr",
        32'(flashAddr), 32'(a));
    lat = 0; got = 0;
    for (int i = 0; i < INIT_WAIT + 4 && !got; i++) begin
      @(negedge clk); lat++;
      if (rspValid) got = 1;
    end
    chk(lat == expW, expHit ? "R5" : "R4", "latency", 32'(lat), 32'(expW));
    chk(rspData == word(a), "R6", "data", 32'(rspData), 32'(word(a)));
    if (expHit) modelHits++;
    if (lat == PAGE_WAIT) obsHits++;
    mValid = 1; mTag = a[ADDR_W-1:PB]; idleRun = 0; lastWord = word(a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady && !rspValid && flashCeN && flashOeN, "R1", "in reset",
        {28'd0, reqReady, rspValid, flashCeN, flashOeN}, 32'hB);
    rstN = 1;
    @(negedge clk);
    chk(reqReady && !rspValid && flashCeN && flashOeN, "R1", "after reset",
        {28'd0, reqReady, rspValid, flashCeN, flashOeN}, 32'hB);
    idleRun = 0;
    // R7: every offset in one page, first misses, rest hit
    for (int o = 0; o < 16; o++) doRead({8'h12, 4'(o)}, 0);
    checkPulse();
    // descending offsets with one idle cycle between reads
    for (int o = 15; o >= 0; o--) doRead({8'h05, 4'(o)}, 1);
    // R7: same low bits, alternating pages -> all misses
    for (int i = 0; i < 8; i++) doRead({(i % 2 == 1) ? 8'h21 : 8'h20, 4'h3}, 0);
    // repeated address
    doRead(12'h7A9, 0);
    doRead(12'h7A9, 0);
    // R8: idle boundary
    idleWait(IDLE_LIMIT - 1);
    doRead(12'h7A2, 0);
    idleWait(IDLE_LIMIT);
    doRead(12'h7A5, 0);
    checkPulse();
    // sweep every page, two offsets each
    for (int p = 0; p < 256; p++) begin
      doRead({8'(p), 4'(p)}, 0);
      doRead({8'(p), ~4'(p)}, p % 3);
    end
    chk(obsHits == modelHits, "R5", "hit count", 32'(obsHits), 32'(modelHits));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule